// File: doc/BRIEF.md
# Keyboard Character Input Port

This block is a small memory-mapped input port for single characters. A key source offers an 8-bit character code on a valid/ready stream. The port latches the code into a 32-bit readable word and raises an interrupt line to say that a character is waiting. Software services the interrupt by reading the code word. That read returns the character and withdraws the interrupt. Stores to the port change nothing.

The key stream never applies back-pressure: `key_ready` is held high, and a transfer takes place in every cycle in which `key_valid` is high. A character that arrives before the previous one has been read is not refused. It overwrites the stored code and is counted as an overrun. Three free-running counters track raised interrupts, received keys and overruns. They can be read at their own word addresses for debug. The register bus is plain control: a one-cycle `bus_valid` strobe with `bus_write` and a word address. Read data is combinational and is valid in the same cycle as the strobe.

Top module: `kbd_input_port`

## Requirements
- R1: After reset the code word reads 0x00000000, `irq` is low and all three counters read 0.
- R2: `key_ready` is always 1. A key transfer stores `key_code` in bits 7:0 of the code word, with bits 31:8 zero. `irq` is high from the next cycle on.
- R3: A read at word address 0 returns the code word as it stands in that cycle. If no key arrives in the same cycle, `irq` is low from the next cycle on. Reads at word addresses 1 to 3 leave `irq` unchanged.
- R4: A write at any word address changes neither the code word, `irq` nor any counter.
- R5: A key that arrives while `irq` is high and no word-0 read happens in that cycle replaces the stored code, keeps `irq` high and increments the overrun count by one.
- R6: When a key and a word-0 read happen in the same cycle, the read returns the old code. From the next cycle on the new code is stored and `irq` is high, and the overrun count does not change.
- R7: The key count increments by one for every key transfer.
- R8: The interrupt count increments by one for every key transfer that is not an overrun, and only then.
- R9: Word address 1 reads the interrupt count, address 2 reads the key count and address 3 reads the overrun count. Each count is zero-extended to 32 bits and wraps at 2^CNT_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| key_valid | input | 1 | A key code is offered |
| key_ready | output | 1 | Always 1; the port never stalls the key source |
| key_code | input | 8 | Character code of the offered key |
| bus_valid | input | 1 | Register access strobe, one cycle per access |
| bus_write | input | 1 | 1 = write (ignored), 0 = read |
| bus_addr | input | 2 | Word address: 0 code, 1 interrupts, 2 keys, 3 overruns |
| bus_rdata | output | 32 | Read data, valid in the cycle of a read strobe |
| irq | output | 1 | Character-pending interrupt |

## Verification
The two functions that can coincide are a key arrival and the clear caused by a word-0 read. The bench drives both in one cycle, both on purpose and through a long stretch of random key and bus traffic. In that cycle it checks that the returned data is the old character. From the next cycle on it checks that the new character is stored, that the interrupt is still high, and that the interrupt count moved while the overrun count did not. A behavioural model of the pending flag and the three counts is compared against `irq` and every read on every clock.

// File: rtl/kbd_pkg.sv
package kbd_pkg;
  localparam int DATA_W = 32;
  localparam int CODE_W = 8;
  localparam int SEL_W  = 2;
  localparam int NUM_CNT = 3;

  typedef enum logic [SEL_W-1:0] {
    SEL_CODE = 2'd0,
    SEL_IRQS = 2'd1,
    SEL_KEYS = 2'd2,
    SEL_OVRS = 2'd3
  } kbd_sel_e;

  // index of each statistic in the counter bank
  localparam int CNT_IRQS = 0;
  localparam int CNT_KEYS = 1;
  localparam int CNT_OVRS = 2;
endpackage

// File: rtl/kbd_event_reg.sv
module kbd_event_reg #(
  parameter int CODE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              key_fire,
  input  logic [CODE_W-1:0] key_code,
  input  logic              clear_req,
  output logic [CODE_W-1:0] code_q,
  output logic              pend_q,
  output logic              overrun_o,
  output logic              raise_o
);
  // a key overruns only if the previous one stays unread this cycle
  assign overrun_o = key_fire & pend_q & ~clear_req;
  assign raise_o   = key_fire & ~overrun_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
      pend_q <= 1'b0;
    end else begin
      if (key_fire) code_q <= key_code;
      // a new key wins over a same-cycle clear
      pend_q <= key_fire | (pend_q & ~clear_req);
    end
  end
endmodule

// File: rtl/kbd_stat_counters.sv
module kbd_stat_counters #(
  parameter int CNT_W = 16,
  parameter int N     = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [N-1:0]            inc,
  output logic [N-1:0][CNT_W-1:0] cnt_o
);
  for (genvar i = 0; i < N; i++) begin : g_cnt
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_o[i] <= '0;
      else if (inc[i]) cnt_o[i] <= cnt_o[i] + 1'b1;
    end
  end
endmodule

// File: rtl/kbd_read_mux.sv
module kbd_read_mux
  import kbd_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  kbd_sel_e                      sel,
  input  logic [CODE_W-1:0]             code,
  input  logic [NUM_CNT-1:0][CNT_W-1:0] cnts,
  output logic [DATA_W-1:0]             rdata
);
  localparam int CPAD = DATA_W - CODE_W;
  localparam int NPAD = DATA_W - CNT_W;

  always_comb begin
    unique case (sel)
      SEL_CODE: rdata = {{CPAD{1'b0}}, code};
      SEL_IRQS: rdata = {{NPAD{1'b0}}, cnts[CNT_IRQS]};
      SEL_KEYS: rdata = {{NPAD{1'b0}}, cnts[CNT_KEYS]};
      SEL_OVRS: rdata = {{NPAD{1'b0}}, cnts[CNT_OVRS]};
      default:  rdata = '0;
    endcase
  end
endmodule

// File: rtl/kbd_input_port.sv
module kbd_input_port
  import kbd_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              key_valid,
  output logic              key_ready,
  input  logic [CODE_W-1:0] key_code,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [SEL_W-1:0]  bus_addr,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  logic                          key_fire;
  logic                          clear_req;
  logic [CODE_W-1:0]             code_q;
  logic                          pend_q;
  logic                          overrun;
  logic                          raise;
  logic [NUM_CNT-1:0]            inc;
  logic [NUM_CNT-1:0][CNT_W-1:0] cnts;
  kbd_sel_e                      sel;

  assign key_ready = 1'b1;
  assign key_fire  = key_valid & key_ready;
  assign sel       = kbd_sel_e'(bus_addr);
  assign clear_req = bus_valid & ~bus_write & (sel == SEL_CODE);

  kbd_event_reg #(.CODE_W(CODE_W)) u_event (
    .clk(clk), .rst_n(rst_n), .key_fire(key_fire), .key_code(key_code),
    .clear_req(clear_req), .code_q(code_q), .pend_q(pend_q),
    .overrun_o(overrun), .raise_o(raise)
  );

  assign inc[CNT_IRQS] = raise;
  assign inc[CNT_KEYS] = key_fire;
  assign inc[CNT_OVRS] = overrun;

  kbd_stat_counters #(.CNT_W(CNT_W), .N(NUM_CNT)) u_cnt (
    .clk(clk), .rst_n(rst_n), .inc(inc), .cnt_o(cnts)
  );

  kbd_read_mux #(.CNT_W(CNT_W)) u_mux (
    .sel(sel), .code(code_q), .cnts(cnts), .rdata(bus_rdata)
  );

  assign irq = pend_q;
endmodule

// File: rtl/kbd_input_port_chk.sv
module kbd_input_port_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             key_valid,
  input logic [7:0]       key_code,
  input logic             bus_valid,
  input logic             bus_write,
  input logic [1:0]       bus_addr,
  input logic             irq,
  input logic [7:0]       code_q,
  input logic [CNT_W-1:0] irq_cnt,
  input logic [CNT_W-1:0] key_cnt,
  input logic [CNT_W-1:0] ovr_cnt
);
  logic rd0;
  assign rd0 = bus_valid && !bus_write && bus_addr == 2'd0;

  a_r2_key_raises_irq: assert property (@(posedge clk) disable iff (!rst_n)
    key_valid |=> irq);
  a_r2_key_loads_code: assert property (@(posedge clk) disable iff (!rst_n)
    key_valid |=> code_q == $past(key_code));
  a_r3_read_clears_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (rd0 && !key_valid) |=> !irq);
  a_r4_write_keeps_state: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_write && !key_valid) |=> ($stable(irq) && $stable(code_q)));
  a_r5_overrun_counts: assert property (@(posedge clk) disable iff (!rst_n)
    (key_valid && irq && !rd0) |=> ovr_cnt == CNT_W'($past(ovr_cnt) + 1'b1));
  a_r6_race_no_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    (key_valid && rd0) |=> $stable(ovr_cnt));
  a_r7_key_counts: assert property (@(posedge clk) disable iff (!rst_n)
    key_valid |=> key_cnt == CNT_W'($past(key_cnt) + 1'b1));
  a_r8_irq_count_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !key_valid |=> $stable(irq_cnt));
endmodule

bind kbd_input_port kbd_input_port_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .key_valid(key_valid), .key_code(key_code),
  .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
  .irq(irq), .code_q(code_q), .irq_cnt(cnts[0]), .key_cnt(cnts[1]),
  .ovr_cnt(cnts[2])
);

// File: tb/test_kbd_input_port.sv
`timescale 1ns/1ps
module test_kbd_input_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        key_valid = 1'b0;
  logic        key_ready;
  logic [7:0]  key_code = '0;
  logic        bus_valid = 1'b0;
  logic        bus_write = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic [31:0] bus_rdata;
  logic        irq;

  int total = 0;
  int bad = 0;
  bit done = 0;

  // reference state
  int m_code = 0;
  bit m_pend = 0;
  int m_irqs = 0, m_keys = 0, m_ovrs = 0;

  always #2 clk = ~clk;

  kbd_input_port #(.CNT_W(16)) i_kbd_input_port (
    .clk(clk), .rst_n(rst_n), .key_valid(key_valid), .key_ready(key_ready),
    .key_code(key_code), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_rdata(bus_rdata), .irq(irq)
  );

  function automatic logic [31:0] model_read(input logic [1:0] a);
    case (a)
      2'd0: return 32'(m_code);
      2'd1: return 32'(m_irqs % 65536);
      2'd2: return 32'(m_keys % 65536);
      default: return 32'(m_ovrs % 65536);
    endcase
  endfunction

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic step(input bit kv, input logic [7:0] kc, input bit bv,
                      input bit bw, input logic [1:0] ba, input string tag);
    bit rd0;
    @(negedge clk);
    key_valid = kv; key_code = kc;
    bus_valid = bv; bus_write = bw; bus_addr = ba;
    #1;
    check(tag, "irq", 32'(irq), 32'(m_pend));
    check("R2", "key_ready", 32'(key_ready), 32'd1);
    if (bv && !bw) check(tag, "rdata", bus_rdata, model_read(ba));
    @(posedge clk);
    rd0 = bv && !bw && ba == 2'd0;
    if (kv) begin
      m_keys++;
      if (m_pend && !rd0) m_ovrs++;
      else m_irqs++;
      m_code = int'(kc);
    end
    m_pend = kv || (m_pend && !rd0);
  endtask

  task automatic idle(input string tag);
    step(0, 8'h00, 0, 0, 2'd0, tag);
  endtask

  task automatic rd(input logic [1:0] a, input string tag);
    step(0, 8'h00, 1, 0, a, tag);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R1 reset state
    for (int a = 0; a < 4; a++) rd(2'(a), "R1");
    // R2 and R3 basic key then read
    step(1, 8'h41, 0, 0, 2'd0, "R2");
    rd(2'd1, "R3");
    rd(2'd2, "R3");
    check("R3", "irq kept after debug reads", 32'(irq), 32'd1);
    rd(2'd0, "R3");
    idle("R3");
    check("R3", "irq cleared", 32'(irq), 32'd0);
    // R4 writes ignored, with a key pending
    step(1, 8'h62, 0, 0, 2'd0, "R2");
    for (int a = 0; a < 4; a++) step(0, 8'h00, 1, 1, 2'(a), "R4");
    check("R4", "irq after writes", 32'(irq), 32'd1);
    rd(2'd0, "R4");
    // R5 overrun
    step(1, 8'h10, 0, 0, 2'd0, "R5");
    step(1, 8'h11, 0, 0, 2'd0, "R5");
    step(1, 8'hFE, 1, 0, 2'd2, "R5");
    rd(2'd3, "R5");
    rd(2'd0, "R5");
    // R6 key and clearing read in the same cycle
    step(1, 8'h33, 0, 0, 2'd0, "R6");
    step(1, 8'h7A, 1, 0, 2'd0, "R6");
    idle("R6");
    check("R6", "irq after race", 32'(irq), 32'd1);
    rd(2'd3, "R6");
    rd(2'd0, "R6");
    // R6 race with nothing pending, then write during key
    step(1, 8'h05, 1, 0, 2'd0, "R6");
    step(1, 8'h06, 1, 1, 2'd0, "R4");
    // R7 R8 R9 counters
    rd(2'd1, "R8");
    rd(2'd2, "R7");
    rd(2'd3, "R9");
    // mixed random traffic
    for (int i = 0; i < 2000; i++) begin
      step(($urandom % 3) == 0, 8'($urandom), ($urandom % 2) == 0,
           ($urandom % 4) == 0, 2'($urandom), "R9");
    end
    idle("R9");
    for (int a = 0; a < 4; a++) rd(2'(a), "R9");
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule